// File: doc/BRIEF.md
# SPI Byte Slave with Select-Framed Phase

This block is the receive-and-transmit end of a four-wire serial link in which another device owns the serial clock. The serial clock, the data input and the active-low select arrive asynchronously. The block brings them into its own clock domain through synchroniser chains. It then finds the clock edges on the synchronised copy and moves one byte in each direction per transfer. The most significant bit goes first on both lines.

Clock polarity and phase are static configuration pins and must only change while select is high. With phase 0, the falling edge of select counts as the first output event. The first outgoing bit therefore appears as soon as select is seen low, and select must rise between bytes to start the next one. With phase 1, select may stay low across a run of bytes, and the block counts byte boundaries from the clock edges alone.

The local side writes the next outgoing byte into a single holding register. It receives each completed incoming byte together with a one-cycle strobe. If the local side supplies no fresh byte in time, the block sends the held byte again and raises an underrun flag. The serial clock must run no faster than one quarter of the system clock.

Top module: `spi_byte_slave`

## Requirements
- R1: While synchronised select is high, the bit position is held at zero and no byte completes. A select rise after only part of a byte throws away that partial byte, so rxValid does not pulse for it.
- R2: With cfgCpha=0, the bit at position 7 of the shifter is on misoOut within three clocks of select falling. Incoming bits are sampled on leading clock edges, and the next outgoing bit is moved out on trailing edges.
- R3: With cfgCpha=1, outgoing bits change on leading edges and incoming bits are sampled on trailing edges. Select may stay low for several bytes, and every eight sampling edges form one byte.
- R4: Each byte holds 8 bits and is sent and received MSB first. One clock after the eighth sampling edge, rxData takes the received byte and rxValid is high for exactly one clock.
- R5: cfgCpol sets the idle clock level. The leading edge is rising when cfgCpol=0 and falling when cfgCpol=1.
- R6: A txLoad pulse copies txData into the holding register. The shifter is loaded from the holding register when select falls. With cfgCpha=1, it is also loaded at each byte boundary while select stays low.
- R7: At each shifter load, if no txLoad happened since the previous load, the held byte is sent again and txUnderrun becomes 1. Otherwise txUnderrun becomes 0. txUnderrun keeps its value between loads and is 0 after reset.
- R8: misoOe is 1 exactly while synchronised select is low. After reset, misoOe is 0, rxValid is 0 and rxData is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgCpol | input | 1 | Idle level of the serial clock |
| cfgCpha | input | 1 | Phase: 0 samples on leading edges, 1 samples on trailing edges |
| sckIn | input | 1 | Serial clock from the remote side, asynchronous |
| mosiIn | input | 1 | Serial data into the block, asynchronous |
| selN | input | 1 | Active-low select, asynchronous |
| txData | input | 8 | Next byte to send |
| txLoad | input | 1 | Write strobe for the holding register |
| misoOut | output | 1 | Serial data out of the block |
| misoOe | output | 1 | Output enable for misoOut |
| rxData | output | 8 | Last complete received byte |
| rxValid | output | 1 | One-clock strobe for a new rxData |
| txUnderrun | output | 1 | The byte now being sent is a repeat |

## Verification
The assertions assume that the serial clock is slow enough for every level to be seen by the synchronisers for several system clocks. They also assume that the configuration pins stay still while a frame is open, so that each synchronised clock change is exactly one leading or trailing edge. The stimulus acts as the remote side: it holds each clock level for five system clocks, changes polarity and phase only while select is high, and waits several clocks after select changes before the first clock edge. It covers all four clock modes, a held-low multi-byte run with phase 1, an abandoned half byte, and transfers with and without a fresh transmit byte.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  // Strobes handed from the control to the datapath each clock
  typedef struct packed {
    logic sampleStb;  // take one incoming bit
    logic shiftStb;   // advance the outgoing shifter
    logic loadStb;    // reload the shifter from the holding register
    logic doneStb;    // this sample completes a byte
  } ctrlStb_t;
endpackage

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_slave_ctrl.sv
module spi_slave_ctrl
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgCpol,
  input  logic     cfgCpha,
  input  logic     sckS,
  input  logic     selS,
  output ctrlStb_t stb,
  output logic     oe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic             sckPrev, selPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             sckEdge, leadEdge, trailEdge, selFall, active;
  logic             sampleEv, driveEv, doneEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      selPrev <= 1'b1;
    end else begin
      sckPrev <= sckS;
      selPrev <= selS;
    end
  end

  always_comb begin
    sckEdge   = sckS ^ sckPrev;
    leadEdge  = sckEdge && (sckS != cfgCpol);
    trailEdge = sckEdge && (sckS == cfgCpol);
    selFall   = selPrev && !selS;
    active    = !selS && !selPrev;
    sampleEv  = active && (cfgCpha ? trailEdge : leadEdge);
    driveEv   = active && (cfgCpha ? leadEdge : trailEdge) && (bitCnt != '0);
    doneEv    = sampleEv && (bitCnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (selS || selFall) begin
      bitCnt <= '0;
    end else if (sampleEv) begin
      bitCnt <= doneEv ? '0 : bitCnt + 1'b1;
    end
  end

  always_comb begin
    stb.sampleStb = sampleEv;
    stb.shiftStb  = driveEv;
    stb.doneStb   = doneEv;
    stb.loadStb   = selFall || (doneEv && cfgCpha);
  end

  assign oe = !selS;

  // R1: an idle select parks the bit position at zero
  p_idle_count_r1: assert property (@(posedge clk) disable iff (!rstN)
    selS |=> (bitCnt == '0));

  // R4: each mid-byte sample advances the bit position by one
  p_count_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sampleStb && bitCnt != LAST) |=> (bitCnt == $past(bitCnt) + 1'b1));
endmodule

// File: rtl/spi_slave_dp.sv
module spi_slave_dp
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              mosiS,
  input  logic [DATA_W-1:0] txData,
  input  logic              txLoad,
  output logic              misoOut,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              txUnderrun
);
  logic [DATA_W-1:0] holdReg, txShift, rxShift;
  logic              fresh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (txLoad) begin
      holdReg <= txData;
    end
  end

  // A load in the same clock as a shifter reload counts for the next reload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fresh      <= 1'b0;
      txUnderrun <= 1'b0;
    end else if (stb.loadStb) begin
      fresh      <= txLoad;
      txUnderrun <= !fresh;
    end else if (txLoad) begin
      fresh <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (stb.loadStb) begin
      txShift <= holdReg;
    end else if (stb.shiftStb) begin
      txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= stb.doneStb;
      if (stb.sampleStb) rxShift <= {rxShift[DATA_W-2:0], mosiS};
      if (stb.doneStb)   rxData  <= {rxShift[DATA_W-2:0], mosiS};
    end
  end

  assign misoOut = txShift[DATA_W-1];

  // R4: the completion strobe never lasts two clocks
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R6: the holding register changes only on a write
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !txLoad |=> $stable(holdReg));

  // R7: the underrun flag changes only at a shifter reload
  p_underrun_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadStb |=> $stable(txUnderrun));

  // R2: the outgoing bit holds between output events
  p_tx_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadStb && !stb.shiftStb) |=> $stable(misoOut));
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              selN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txLoad,
  output logic              misoOut,
  output logic              misoOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              txUnderrun
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] rawBus, syncBus;
  logic              selS, sckS, mosiS;
  ctrlStb_t          stb;

  assign rawBus = {selN, sckIn, mosiIn};
  assign {selS, sckS, mosiS} = syncBus;

  spi_slave_sync #(
    .W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) sync_i (
    .clk(clk), .rstN(rstN), .d(rawBus), .q(syncBus)
  );

  spi_slave_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .sckS(sckS), .selS(selS), .stb(stb), .oe(misoOe)
  );

  spi_slave_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .mosiS(mosiS),
    .txData(txData), .txLoad(txLoad), .misoOut(misoOut),
    .rxData(rxData), .rxValid(rxValid), .txUnderrun(txUnderrun)
  );
endmodule

// File: tb/spi_byte_slave_tb_top.sv
module spi_byte_slave_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgCpol = 1'b0, cfgCpha = 1'b0;
  logic       sckIn = 1'b0, mosiIn = 1'b0, selN = 1'b1;
  logic [7:0] txData = 8'h00;
  logic       txLoad = 1'b0;
  logic       misoOut, misoOe, rxValid, txUnderrun;
  logic [7:0] rxData;

  int  nChecks = 0, nFails = 0;
  logic [7:0] rxQ[$];
  logic       prevValid = 1'b0;

  always #5 clk = ~clk;

  spi_byte_slave dut_i (
    .clk(clk), .rstN(rstN), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .sckIn(sckIn), .mosiIn(mosiIn), .selN(selN), .txData(txData),
    .txLoad(txLoad), .misoOut(misoOut), .misoOe(misoOe),
    .rxData(rxData), .rxValid(rxValid), .txUnderrun(txUnderrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected byte per completion strobe (R4)
  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid && prevValid) check(1'b0, "R4 pulse width", 2, 1);
      if (rxValid) begin
        if (rxQ.size() == 0) check(1'b0, "R1 unexpected byte", rxData, 0);
        else begin
          logic [7:0] e;
          e = rxQ.pop_front();
          check(rxData == e, "R4 rx byte", rxData, e);
        end
      end
    end
    prevValid = rxValid;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadTx(input logic [7:0] b);
    txData = b; txLoad = 1'b1;
    waitClk(1);
    txLoad = 1'b0;
  endtask

  task automatic setMode(input logic pol, input logic pha);
    cfgCpol = pol; cfgCpha = pha; sckIn = pol;
    waitClk(6);
  endtask

  task automatic selOpen();
    selN = 1'b0;
    waitClk(6);
    check(misoOe == 1'b1, "R8 oe while selected", misoOe, 1);
  endtask

  task automatic selClose();
    waitClk(5);
    selN = 1'b1;
    waitClk(6);
    check(misoOe == 1'b0, "R8 oe after deselect", misoOe, 0);
  endtask

  // Remote-side byte exchange over nBits bits; the expected byte goes to the scoreboard
  task automatic xfer(input logic [7:0] mo, input int nBits, output logic [7:0] mi);
    mi = 8'h00;
    if (nBits == 8) rxQ.push_back(mo);
    for (int i = 7; i > 7 - nBits; i--) begin
      if (!cfgCpha) begin
        mosiIn = mo[i];
        waitClk(5);
        mi[i] = misoOut;
        sckIn = ~cfgCpol;
        waitClk(5);
        sckIn = cfgCpol;
      end else begin
        sckIn = ~cfgCpol;
        mosiIn = mo[i];
        waitClk(5);
        mi[i] = misoOut;
        sckIn = cfgCpol;
        waitClk(5);
      end
    end
    waitClk(4);
  endtask

  initial begin
    logic [7:0] got;
    waitClk(3);
    check(misoOe == 1'b0, "R8 reset oe", misoOe, 0);
    check(rxValid == 1'b0, "R8 reset valid", rxValid, 0);
    check(rxData == 8'h00, "R8 reset data", rxData, 0);
    check(txUnderrun == 1'b0, "R7 reset underrun", txUnderrun, 0);
    rstN = 1'b1;
    waitClk(3);

    // R2 R5: mode cpol0 cpha0
    setMode(1'b0, 1'b0);
    loadTx(8'hA5);
    selOpen();
    check(misoOut == 1'b1, "R2 first bit at select", misoOut, 1);
    xfer(8'h3C, 8, got);
    check(got == 8'hA5, "R2 miso byte mode0", got, 8'hA5);
    check(txUnderrun == 1'b0, "R7 fresh byte", txUnderrun, 0);
    selClose();

    // R5: cpol1 cpha0
    setMode(1'b1, 1'b0);
    loadTx(8'h4E);
    selOpen();
    xfer(8'hC3, 8, got);
    check(got == 8'h4E, "R5 miso byte cpol1", got, 8'h4E);
    selClose();

    // R3 R5: cpol0 cpha1, then cpol1 cpha1
    setMode(1'b0, 1'b1);
    loadTx(8'h81);
    selOpen();
    xfer(8'h7E, 8, got);
    check(got == 8'h81, "R3 miso byte mode1", got, 8'h81);
    selClose();
    setMode(1'b1, 1'b1);
    loadTx(8'h19);
    selOpen();
    xfer(8'hE4, 8, got);
    check(got == 8'h19, "R3 miso byte mode3", got, 8'h19);
    selClose();

    // R3 R6 R7: select held low across three bytes
    setMode(1'b0, 1'b1);
    loadTx(8'hB1);
    selOpen();
    loadTx(8'hC2);
    xfer(8'h12, 8, got);
    check(got == 8'hB1, "R3 burst byte0", got, 8'hB1);
    check(txUnderrun == 1'b0, "R7 burst reload fresh", txUnderrun, 0);
    xfer(8'h34, 8, got);
    check(got == 8'hC2, "R6 burst byte1", got, 8'hC2);
    check(txUnderrun == 1'b1, "R7 burst reload stale", txUnderrun, 1);
    xfer(8'h56, 8, got);
    check(got == 8'hC2, "R7 burst byte2 repeat", got, 8'hC2);
    selClose();

    // R1: abandoned half byte, then a clean byte
    setMode(1'b0, 1'b0);
    loadTx(8'h11);
    selOpen();
    xfer(8'hFF, 4, got);
    selClose();
    check(rxQ.size() == 0, "R1 no pending byte", rxQ.size(), 0);
    loadTx(8'h96);
    selOpen();
    xfer(8'h5A, 8, got);
    check(got == 8'h96, "R1 byte after abort", got, 8'h96);
    selClose();

    // R7: no new byte before select falls
    selOpen();
    check(txUnderrun == 1'b1, "R7 stale at select", txUnderrun, 1);
    xfer(8'h0F, 8, got);
    check(got == 8'h96, "R7 repeat at select", got, 8'h96);
    selClose();

    waitClk(5);
    check(rxQ.size() == 0, "R4 all bytes seen", rxQ.size(), 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule